// File: doc/BRIEF.md
# Trigger Gate with Filter-Latency Compensation

This block sits after a linear-phase decimating FIR chain in an acquisition front end. It receives the filtered sample stream, which carries a valid strobe, along with a sync pulse, a start trigger and a group-delay setting. The group delay is given as a count of valid output samples. A sync pulse captures that setting and starts a settling period. The block accepts no start trigger until that many samples have passed after the sync.

Once settled, the block raises a ready flag and waits for a trigger. After it accepts a trigger, it lets one further group delay of samples go by, then opens the gate. The first sample released is therefore the one the filter produced from the input instant of the trigger, which cancels the filter latency. The trigger-to-data latency is the same however long the block waits in the ready state.

A trigger that arrives during settling is dropped and raises a sticky error flag. A stop input returns the block to idle. A new sync restarts settling from any state. All logic runs on one clock and uses the valid strobe as a clock enable.

Top module: `trig_align_gate`

## Requirements
- R1: While reset is high and on the first cycle after it, `ready_o`, `early_err_o` and `out_vld_o` are all 0.
- R2: A sync pulse captures `dly_cfg_i` as D. `ready_o` stays 0 through the cycle in which the D-th valid sample after the sync edge is taken. It goes to 1 one cycle later, including the case D = 0.
- R3: Changes to `dly_cfg_i` after the sync edge have no effect on settling or streaming until the next sync.
- R4: A trigger during settling, with no sync in the same cycle, is ignored. `early_err_o` is set from the next cycle on and stays set through stop pulses and later triggers until the next sync clears it.
- R5: After a trigger is accepted while `ready_o` is 1, no sample is output for the first D valid samples taken after the trigger edge. The (D+1)-th one is output with `out_vld_o` = 1 and its data unchanged, one cycle after it was taken.
- R6: The number of valid samples between the trigger and the first output sample does not depend on how long the block stayed ready before the trigger.
- R7: After the first output sample, every valid input sample is output one cycle later with unchanged data. No output is produced in a cycle without an input sample.
- R8: A stop pulse without a sync returns the block to idle. From the next cycle on, `ready_o` and `out_vld_o` are 0 until a new sync and trigger.
- R9: A sync pulse restarts settling from any state and wins over stop and trigger in the same cycle. On the next cycle `ready_o`, `out_vld_o` and `early_err_o` are 0, and a trigger in that same cycle neither starts streaming nor sets the error.
- R10: Triggers while idle, while counting off the delay, or while streaming are ignored and do not set `early_err_o`.
- R11: From a sync pulse to the first output sample, at least 2·D+1 valid samples are taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, derived from the shared reference |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Sync pulse: captures delay, restarts settling |
| stop_i | input | 1 | Stop request, returns to idle |
| trig_i | input | 1 | Start trigger |
| dly_cfg_i | input | DLY_W | Filter group delay in valid-sample counts |
| smp_vld_i | input | 1 | Input sample valid strobe |
| smp_dat_i | input | DATA_W | Filtered input sample |
| out_vld_o | output | 1 | Aligned output sample valid |
| out_dat_o | output | DATA_W | Aligned output sample |
| ready_o | output | 1 | Settled and waiting for a trigger |
| early_err_o | output | 1 | Sticky: a trigger arrived during settling |

## Verification
Two pairs of events can land in the same cycle: a sync pulse together with a trigger and a stop, and a stop pulse together with a valid sample while streaming. The bench drives all three controls in one cycle during streaming. It then expects that the trigger was not taken and that no error was raised, and that settling restarts with the newly captured delay. In a separate cycle it drives a stop alongside a sample and expects that sample not to be output and the ready flag to stay low afterwards.

// File: rtl/trig_align_gate_pkg.sv
package trig_align_gate_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_ARMED  = 3'd2,
    ST_DELAY  = 3'd3,
    ST_STREAM = 3'd4
  } gate_st_e;

endpackage

// File: rtl/gate_dly_cnt.sv
module gate_dly_cnt #(
  parameter int DLY_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DLY_W-1:0] cfg,
  input  logic             clr,
  input  logic             inc,
  output logic             hit,
  output logic [DLY_W-1:0] dly_q
);

  logic [DLY_W-1:0] cnt_q;

  // delay value is captured on sync only
  always_ff @(posedge clk) begin
    if (rst) begin
      dly_q <= '0;
      cnt_q <= '0;
    end else begin
      if (load) dly_q <= cfg;
      if (clr)      cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hit = (cnt_q == dly_q);

endmodule

// File: rtl/gate_fsm.sv
module gate_fsm
  import trig_align_gate_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sync_i,
  input  logic     stop_i,
  input  logic     trig_i,
  input  logic     vld_i,
  input  logic     hit_i,
  output gate_st_e st_o,
  output logic     ready_o,
  output logic     err_o,
  output logic     emit_o,
  output logic     cnt_clr_o,
  output logic     cnt_inc_o
);

  gate_st_e st_q, st_d;
  logic     quiet;
  logic     take_trig;

  assign quiet     = sync_i | stop_i;
  assign take_trig = (st_q == ST_ARMED) & trig_i & ~quiet;

  always_comb begin
    st_d = st_q;
    if (sync_i) begin
      st_d = ST_SETTLE;
    end else if (stop_i) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_SETTLE: if (hit_i)          st_d = ST_ARMED;
        ST_ARMED:  if (trig_i)         st_d = ST_DELAY;
        ST_DELAY:  if (vld_i && hit_i) st_d = ST_STREAM;
        default:   st_d = st_q;
      endcase
    end
  end

  always_comb begin
    emit_o = 1'b0;
    if (!quiet && vld_i) begin
      if (st_q == ST_STREAM)              emit_o = 1'b1;
      else if (st_q == ST_DELAY && hit_i) emit_o = 1'b1;
    end
  end

  assign cnt_clr_o = sync_i | take_trig;
  assign cnt_inc_o = vld_i & ~hit_i & ~quiet &
                     ((st_q == ST_SETTLE) | (st_q == ST_DELAY));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      ready_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      st_q    <= st_d;
      ready_o <= (st_d == ST_ARMED);
      if (sync_i)
        err_o <= 1'b0;
      else if (trig_i && st_q == ST_SETTLE)
        err_o <= 1'b1;
    end
  end

  assign st_o = st_q;

endmodule

// File: rtl/gate_out_stage.sv
module gate_out_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              emit,
  input  logic [DATA_W-1:0] dat_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] dat_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      dat_o <= '0;
    end else begin
      vld_o <= emit;
      if (emit) dat_o <= dat_i;
    end
  end

endmodule

// File: rtl/trig_align_gate.sv
module trig_align_gate
  import trig_align_gate_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DLY_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_i,
  input  logic              stop_i,
  input  logic              trig_i,
  input  logic [DLY_W-1:0]  dly_cfg_i,
  input  logic              smp_vld_i,
  input  logic [DATA_W-1:0] smp_dat_i,
  output logic              out_vld_o,
  output logic [DATA_W-1:0] out_dat_o,
  output logic              ready_o,
  output logic              early_err_o
);

  gate_st_e         st;
  logic             hit, emit, cnt_clr, cnt_inc;
  logic [DLY_W-1:0] dly_lat;

  gate_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .sync_i    (sync_i),
    .stop_i    (stop_i),
    .trig_i    (trig_i),
    .vld_i     (smp_vld_i),
    .hit_i     (hit),
    .st_o      (st),
    .ready_o   (ready_o),
    .err_o     (early_err_o),
    .emit_o    (emit),
    .cnt_clr_o (cnt_clr),
    .cnt_inc_o (cnt_inc)
  );

  gate_dly_cnt #(.DLY_W(DLY_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .load  (sync_i),
    .cfg   (dly_cfg_i),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .hit   (hit),
    .dly_q (dly_lat)
  );

  gate_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk   (clk),
    .rst   (rst),
    .emit  (emit),
    .dat_i (smp_dat_i),
    .vld_o (out_vld_o),
    .dat_o (out_dat_o)
  );

endmodule

// File: rtl/trig_align_gate_chk.sv
module trig_align_gate_chk
  import trig_align_gate_pkg::*;
#(
  parameter int DLY_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             sync_i,
  input logic             stop_i,
  input logic             trig_i,
  input logic             ready_o,
  input logic             early_err_o,
  input logic             out_vld_o,
  input gate_st_e         st,
  input logic [DLY_W-1:0] dly_lat
);

  AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    sync_i |=> (!early_err_o && !ready_o && !out_vld_o)); // R9

  AST_STOP_QUIETS: assert property (@(posedge clk) disable iff (rst)
    (stop_i && !sync_i) |=> (!ready_o && !out_vld_o)); // R8

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(early_err_o) |-> ($past(trig_i) && $past(st) == ST_SETTLE)); // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (early_err_o && !sync_i) |=> early_err_o); // R4

  AST_OUT_AFTER_TRIG: assert property (@(posedge clk) disable iff (rst)
    out_vld_o |-> ($past(st) == ST_DELAY || $past(st) == ST_STREAM)); // R5

  AST_READY_NO_OUT: assert property (@(posedge clk) disable iff (rst)
    !(ready_o && out_vld_o)); // R10

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(sync_i) |-> $stable(dly_lat)); // R3

endmodule

bind trig_align_gate trig_align_gate_chk #(.DLY_W(DLY_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sync_i      (sync_i),
  .stop_i      (stop_i),
  .trig_i      (trig_i),
  .ready_o     (ready_o),
  .early_err_o (early_err_o),
  .out_vld_o   (out_vld_o),
  .st          (st),
  .dly_lat     (dly_lat)
);

// File: tb/trig_align_gate_tb.sv
module trig_align_gate_tb;

  localparam int DATA_W = 16;
  localparam int DLY_W  = 12;

  logic              clk = 1'b0;
  logic              rst, sync_i, stop_i, trig_i, smp_vld_i;
  logic [DLY_W-1:0]  dly_cfg_i;
  logic [DATA_W-1:0] smp_dat_i;
  logic              out_vld_o, ready_o, early_err_o;
  logic [DATA_W-1:0] out_dat_o;

  int total = 0;
  int bad   = 0;
  logic [DATA_W-1:0] seq = 16'h0100;
  logic [DATA_W-1:0] last_dat;

  always #5 clk = ~clk;

  trig_align_gate #(.DATA_W(DATA_W), .DLY_W(DLY_W)) u_dut (
    .clk(clk), .rst(rst), .sync_i(sync_i), .stop_i(stop_i), .trig_i(trig_i),
    .dly_cfg_i(dly_cfg_i), .smp_vld_i(smp_vld_i), .smp_dat_i(smp_dat_i),
    .out_vld_o(out_vld_o), .out_dat_o(out_dat_o), .ready_o(ready_o),
    .early_err_o(early_err_o)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle at a falling edge; results visible at the next falling edge
  task automatic cyc(input logic v, input logic s, input logic t, input logic p);
    smp_vld_i = v; sync_i = s; trig_i = t; stop_i = p;
    smp_dat_i = v ? seq : 16'hdead;
    last_dat  = seq;
    @(negedge clk);
    if (v) seq = seq + 1'b1;
    smp_vld_i = 0; sync_i = 0; trig_i = 0; stop_i = 0;
  endtask

  // settle with delay d: sync, then d valid samples, then ready
  task automatic settle(input int d, input string req);
    dly_cfg_i = DLY_W'(d);
    cyc(0, 1, 0, 0);
    dly_cfg_i = DLY_W'(d + 5); // later edits must not matter (R3)
    for (int i = 0; i < d; i++) begin
      cyc(1, 0, 0, 0);
      chk(ready_o == 0, req, ready_o, 0);
    end
    cyc(0, 0, 0, 0);
    chk(ready_o == 1, req, ready_o, 1);
  endtask

  // trigger and expect first output on the (d+1)-th valid sample
  task automatic trig_and_stream(input int d, input int wait_c, input string req);
    for (int i = 0; i < wait_c; i++) cyc(0, 0, 0, 0);
    chk(ready_o == 1, req, ready_o, 1);
    cyc(0, 0, 1, 0);
    chk(ready_o == 0, req, ready_o, 0);
    for (int i = 0; i < d; i++) begin
      cyc(1, 0, 0, 0);
      chk(out_vld_o == 0, req, out_vld_o, 0);
    end
    cyc(1, 0, 0, 0);
    chk(out_vld_o == 1 && out_dat_o == last_dat, req, out_dat_o, last_dat);
  endtask

  task automatic t_reset;
    rst = 1; sync_i = 0; stop_i = 0; trig_i = 0; smp_vld_i = 0;
    dly_cfg_i = '0; smp_dat_i = '0;
    repeat (3) @(negedge clk);
    chk(!ready_o && !early_err_o && !out_vld_o, "R1 during reset", ready_o, 0);
    rst = 0;
    cyc(1, 0, 0, 0);
    chk(!ready_o && !early_err_o && !out_vld_o, "R1 after reset", out_vld_o, 0);
  endtask

  task automatic t_basic;
    settle(3, "R2 R3 settle d=3");
    // R5 R11: 3 settle + 4 after trigger >= 2*3+1 valid samples
    trig_and_stream(3, 0, "R5 R11 first aligned sample");
    // R7 pass-through with gaps
    cyc(0, 0, 0, 0);
    chk(out_vld_o == 0, "R7 no output on gap", out_vld_o, 0);
    cyc(1, 0, 0, 0);
    chk(out_vld_o == 1 && out_dat_o == last_dat, "R7 pass-through", out_dat_o, last_dat);
    // R10 trigger while streaming
    cyc(1, 0, 1, 0);
    chk(out_vld_o == 1 && early_err_o == 0, "R10 trig while streaming", early_err_o, 0);
    // R8 stop together with a sample
    cyc(1, 0, 0, 1);
    chk(out_vld_o == 0 && ready_o == 0, "R8 stop quiets output", out_vld_o, 0);
    cyc(1, 0, 0, 0);
    chk(out_vld_o == 0, "R8 idle after stop", out_vld_o, 0);
    cyc(0, 0, 1, 0);
    cyc(1, 0, 0, 0);
    chk(out_vld_o == 0 && early_err_o == 0, "R10 trig while idle", early_err_o, 0);
  endtask

  task automatic t_wait;
    settle(2, "R2 settle d=2");
    trig_and_stream(2, 25, "R6 latency after long wait");
  endtask

  task automatic t_early;
    dly_cfg_i = 4;
    cyc(0, 1, 0, 0);
    cyc(1, 0, 1, 0);
    chk(early_err_o == 1 && ready_o == 0, "R4 early trig flags", early_err_o, 1);
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0);
    chk(ready_o == 1 && early_err_o == 1, "R4 early trig ignored", ready_o, 1);
    cyc(0, 0, 0, 1);
    chk(early_err_o == 1, "R4 sticky through stop", early_err_o, 1);
    cyc(0, 1, 0, 0);
    chk(early_err_o == 0, "R4 cleared by sync", early_err_o, 1'b0);
    cyc(0, 0, 0, 1);
  endtask

  task automatic t_sync_collide;
    settle(1, "R2 settle d=1");
    trig_and_stream(1, 0, "R5 d=1");
    dly_cfg_i = 2;
    cyc(1, 1, 1, 1);
    chk(!out_vld_o && !ready_o && !early_err_o, "R9 sync wins", out_vld_o, 0);
    dly_cfg_i = 9;
    cyc(1, 0, 0, 0);
    chk(ready_o == 0 && out_vld_o == 0, "R9 trig not taken", ready_o, 0);
    cyc(1, 0, 0, 0);
    chk(ready_o == 0, "R9 R3 still settling d=2", ready_o, 0);
    cyc(0, 0, 0, 0);
    chk(ready_o == 1 && early_err_o == 0, "R9 resettled with new d", ready_o, 1);
    // R10 trigger while counting off the delay
    cyc(0, 0, 1, 0);
    cyc(1, 0, 1, 0);
    chk(early_err_o == 0 && out_vld_o == 0, "R10 trig while delaying", early_err_o, 0);
    cyc(1, 0, 0, 0);
    chk(out_vld_o == 0, "R5 still delaying", out_vld_o, 0);
    cyc(1, 0, 0, 0);
    chk(out_vld_o == 1 && out_dat_o == last_dat, "R5 d=2 first sample", out_dat_o, last_dat);
  endtask

  task automatic t_zero;
    dly_cfg_i = 0;
    cyc(0, 1, 0, 0);
    chk(ready_o == 0, "R2 d=0 one settle cycle", ready_o, 0);
    cyc(0, 0, 0, 0);
    chk(ready_o == 1, "R2 d=0 ready", ready_o, 1);
    cyc(0, 0, 1, 0);
    cyc(1, 0, 0, 0);
    chk(out_vld_o == 1 && out_dat_o == last_dat, "R5 d=0 first sample", out_dat_o, last_dat);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_wait();
    t_early();
    t_sync_collide();
    t_zero();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule